// File: doc/BRIEF.md
# Serial Command Receiver with Readback

This block sits inside each addressable chip on a board and receives commands over three single-bit lanes that share one serial clock: a frame lane, an address lane and a data lane. Each command is sixteen bits long on every lane and is sent most significant bit first. The first bit on the frame lane is always 1 and marks the start of a command. Four frame-word bits further on carry the destination chip number. When that number equals the chip's own ID, the block issues a one-cycle write strobe. The strobe carries the 16-bit address and the 16-bit data gathered from the other two lanes.

Any command addressed to the chip also serves as a read request. In the strobe cycle the surrounding register file reports, on `rdValid`, whether the address can be read, and presents the word on `rdWord`. The block always clears its response register on an accepted command. When the address is readable it loads the word instead. It then shifts the word out on a return data lane, and a return frame lane is high only during the first bit. A new command can start while a readback is still running, so commands can be sent back to back with no idle gap.

Top module: `ser_cmd_rx`

## Requirements
- R1: While no command is being received, a 0 on `frmIn` is ignored. A 1 sampled on `frmIn` at clock edge n starts a command, and that sample is frame-word bit 15.
- R2: Edges n+1 to n+15 sample the remaining bits of all three lanes, most significant bit first. During the strobe, `wrAddr` holds the 16-bit word from `addrIn` and `wrData` holds the 16-bit word from `dataIn`.
- R3: Frame-word bits 14..11 (bit 14 is the chip-number MSB) are compared with `chipId`. On a mismatch there is no strobe, the response register is left as it was, and any readback in progress continues unchanged.
- R4: On a match, `wrStrobe` is high for exactly one cycle, between edges n+15 and n+16, and is low at all other times.
- R5: On a match with `rdValid` low in the strobe cycle, the response register is cleared and both return lanes stay 0.
- R6: On a match with `rdValid` high in the strobe cycle, `rdWord` is captured at edge n+16. `dataOut` then shows word bit 15-k between edges n+16+k and n+17+k, for k = 0..15.
- R7: `frmOut` is high only while the first bit (bit 15) of a response is on `dataOut`, which is one cycle per response.
- R8: When no response bits remain, `frmOut` and `dataOut` are 0.
- R9: Once a command has started, later 1s on `frmIn` do not restart it. A new command may start at edge n+16, while the previous response is still being shifted out.
- R10: During reset, `wrStrobe`, `frmOut` and `dataOut` are 0 and the receiver is idle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Serial clock; all lanes are sampled on its rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| chipId | input | 4 | This chip's number, compared with frame bits 14..11 |
| frmIn | input | 1 | Command frame lane |
| addrIn | input | 1 | Command address lane |
| dataIn | input | 1 | Command write-data lane |
| rdValid | input | 1 | The address in `wrAddr` is readable (sampled in the strobe cycle) |
| rdWord | input | 16 | Word to return for that address (sampled in the strobe cycle) |
| wrStrobe | output | 1 | One-cycle write strobe for an accepted command |
| wrAddr | output | 16 | Command address, valid while `wrStrobe` is high |
| wrData | output | 16 | Command write data, valid while `wrStrobe` is high |
| frmOut | output | 1 | Return frame lane, high on the first response bit |
| dataOut | output | 1 | Return data lane, response shifted MSB first |

## Verification
Let edge 0 be the edge that samples the start bit of a command. The strobe and its address and data are due in the cycle after edge 15, and the first response bit with its frame marker is due after edge 16. Response bit 15-k is due after edge 16+k, and the return lanes are due back at 0 after edge 32. The bench drives and samples only at falling edges, and steps through each command one cycle at a time, using this numbering to compute what is due in every cycle. For overlapping commands, the second command's window is shifted by sixteen cycles, so the earlier response is expected during the second command's own reception.

// File: rtl/ser_cmd_rx_pkg.sv
package ser_cmd_rx_pkg;

  // Strobes from the bit-count control to the lane datapath.
  typedef struct packed {
    logic shiftEn;   // sample all three lanes on this edge
    logic lastBit;   // this edge samples the final bit of a command
  } rxCtl_t;

endpackage

// File: rtl/ser_cmd_rx_ctrl.sv
module ser_cmd_rx_ctrl
  import ser_cmd_rx_pkg::*;
#(
  parameter int WORD_W = 16
) (
  input  logic   clk,
  input  logic   rstN,
  input  logic   frmIn,
  output rxCtl_t ctl
);

  localparam int CNT_W = $clog2(WORD_W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(WORD_W - 1);

  logic             busy;
  logic [CNT_W-1:0] bitCnt;

  // An idle receiver starts on a frame bit; a busy one ignores the frame lane.
  always_comb begin
    ctl.shiftEn = busy | frmIn;
    ctl.lastBit = busy && (bitCnt == LAST);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy   <= 1'b0;
      bitCnt <= '0;
    end else if (!busy) begin
      if (frmIn) begin
        busy   <= 1'b1;
        bitCnt <= CNT_W'(1);
      end
    end else if (bitCnt == LAST) begin
      busy   <= 1'b0;
      bitCnt <= '0;
    end else begin
      bitCnt <= bitCnt + CNT_W'(1);
    end
  end

  // R9: the final bit always returns the receiver to idle
  p_idle_after_last_r9: assert property (@(posedge clk) disable iff (!rstN)
    ctl.lastBit |=> !busy);

  // R1: a start bit in idle leaves the receiver busy
  p_start_on_frame_r1: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && frmIn) |=> busy);

endmodule

// File: rtl/ser_cmd_rx_dp.sv
module ser_cmd_rx_dp
  import ser_cmd_rx_pkg::*;
#(
  parameter int WORD_W  = 16,
  parameter int CHIP_W  = 4,
  parameter int CHIP_HI = 14
) (
  input  logic              clk,
  input  logic              rstN,
  input  rxCtl_t            ctl,
  input  logic [CHIP_W-1:0] chipId,
  input  logic              frmIn,
  input  logic              addrIn,
  input  logic              dataIn,
  input  logic              rdValid,
  input  logic [WORD_W-1:0] rdWord,
  output logic              wrStrobe,
  output logic [WORD_W-1:0] wrAddr,
  output logic [WORD_W-1:0] wrData,
  output logic              frmOut,
  output logic              dataOut
);

  localparam int LEFT_W = $clog2(WORD_W + 1);
  localparam logic [LEFT_W-1:0] FULL = LEFT_W'(WORD_W);

  // Frame bits above the chip field fall off the end; only bits CHIP_HI..0 are kept.
  logic [CHIP_HI:0]    frmSr;
  logic [WORD_W-1:0]   addrSr;
  logic [WORD_W-1:0]   dataSr;
  logic                doneQ;
  logic                chipHit;
  logic [WORD_W-1:0]   respSr;
  logic [LEFT_W-1:0]   respLeft;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      frmSr  <= '0;
      addrSr <= '0;
      dataSr <= '0;
      doneQ  <= 1'b0;
    end else begin
      doneQ <= ctl.lastBit;
      if (ctl.shiftEn) begin
        frmSr  <= {frmSr[CHIP_HI-1:0], frmIn};
        addrSr <= {addrSr[WORD_W-2:0], addrIn};
        dataSr <= {dataSr[WORD_W-2:0], dataIn};
      end
    end
  end

  assign chipHit  = (frmSr[CHIP_HI -: CHIP_W] == chipId);
  assign wrStrobe = doneQ & chipHit;
  assign wrAddr   = addrSr;
  assign wrData   = dataSr;

  // Response register: cleared or loaded on each accepted command, then shifted out.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      respSr   <= '0;
      respLeft <= '0;
    end else if (wrStrobe) begin
      respSr   <= rdValid ? rdWord : '0;
      respLeft <= rdValid ? FULL : '0;
    end else if (respLeft != '0) begin
      respSr   <= {respSr[WORD_W-2:0], 1'b0};
      respLeft <= respLeft - LEFT_W'(1);
    end
  end

  assign frmOut  = (respLeft == FULL);
  assign dataOut = respSr[WORD_W-1];

  // R4: the write strobe never lasts two cycles
  p_strobe_pulse_r4: assert property (@(posedge clk) disable iff (!rstN)
    wrStrobe |=> !wrStrobe);

  // R6: a readable command puts the word MSB and the frame marker out next cycle
  p_resp_start_r6: assert property (@(posedge clk) disable iff (!rstN)
    (wrStrobe && rdValid) |=> (frmOut && dataOut == $past(rdWord[WORD_W-1])));

  // R5: an unreadable command leaves both return lanes quiet
  p_resp_clear_r5: assert property (@(posedge clk) disable iff (!rstN)
    (wrStrobe && !rdValid) |=> (!frmOut && !dataOut));

  // R7: the frame marker covers only one bit
  p_frame_once_r7: assert property (@(posedge clk) disable iff (!rstN)
    frmOut |=> !frmOut);

  // R8: nothing left to send means both lanes are 0
  p_quiet_lanes_r8: assert property (@(posedge clk) disable iff (!rstN)
    (respLeft == '0) |-> (!frmOut && !dataOut));

  // R3: a foreign command does not touch an idle response register
  p_foreign_hold_r3: assert property (@(posedge clk) disable iff (!rstN)
    (doneQ && !chipHit && respLeft == '0) |=> (respLeft == '0));

endmodule

// File: rtl/ser_cmd_rx.sv
module ser_cmd_rx
  import ser_cmd_rx_pkg::*;
#(
  parameter int WORD_W  = 16,
  parameter int CHIP_W  = 4,
  parameter int CHIP_HI = 14
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [CHIP_W-1:0] chipId,
  input  logic              frmIn,
  input  logic              addrIn,
  input  logic              dataIn,
  input  logic              rdValid,
  input  logic [WORD_W-1:0] rdWord,
  output logic              wrStrobe,
  output logic [WORD_W-1:0] wrAddr,
  output logic [WORD_W-1:0] wrData,
  output logic              frmOut,
  output logic              dataOut
);

  rxCtl_t ctl;

  ser_cmd_rx_ctrl #(.WORD_W(WORD_W)) u_ctrl (
    .clk   (clk),
    .rstN  (rstN),
    .frmIn (frmIn),
    .ctl   (ctl)
  );

  ser_cmd_rx_dp #(
    .WORD_W  (WORD_W),
    .CHIP_W  (CHIP_W),
    .CHIP_HI (CHIP_HI)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .ctl      (ctl),
    .chipId   (chipId),
    .frmIn    (frmIn),
    .addrIn   (addrIn),
    .dataIn   (dataIn),
    .rdValid  (rdValid),
    .rdWord   (rdWord),
    .wrStrobe (wrStrobe),
    .wrAddr   (wrAddr),
    .wrData   (wrData),
    .frmOut   (frmOut),
    .dataOut  (dataOut)
  );

endmodule

// File: tb/ser_cmd_rx_tb.sv
module ser_cmd_rx_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [3:0]  chipId = 4'd0;
  logic        frmIn = 1'b0;
  logic        addrIn = 1'b0;
  logic        dataIn = 1'b0;
  logic        rdValid = 1'b0;
  logic [15:0] rdWord = 16'h0;
  logic        wrStrobe;
  logic [15:0] wrAddr;
  logic [15:0] wrData;
  logic        frmOut;
  logic        dataOut;

  int nChk = 0;
  int nErr = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;   // 250 MHz

  ser_cmd_rx u_dut (
    .clk(clk), .rstN(rstN), .chipId(chipId), .frmIn(frmIn), .addrIn(addrIn),
    .dataIn(dataIn), .rdValid(rdValid), .rdWord(rdWord), .wrStrobe(wrStrobe),
    .wrAddr(wrAddr), .wrData(wrData), .frmOut(frmOut), .dataOut(dataOut)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nErr++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  // One command, stepped a cycle at a time. t = falling edge before sample edge t.
  // prevStrb/prevRd/prevW describe a preceding command that stopped at t = 15.
  task automatic runCmd(input logic [15:0] frm, input logic [15:0] a, input logic [15:0] d,
                        input logic v, input logic [15:0] w, input int lastT,
                        input logic prevStrb, input logic prevRd, input logic [15:0] prevW);
    logic hit;
    logic pend;
    logic expD;
    logic expF;
    hit  = (frm[14:11] == chipId);
    pend = prevStrb && prevRd;
    for (int t = 0; t <= lastT; t++) begin
      @(negedge clk);
      if (t == 0)       chk("R4 earlier strobe", {31'b0, wrStrobe}, {31'b0, prevStrb});
      else if (t < 16)  chk("R4 no strobe mid-command R9", {31'b0, wrStrobe}, 32'd0);
      else if (t == 16) begin
        chk("R3 R4 strobe on match", {31'b0, wrStrobe}, {31'b0, hit});
        if (hit) begin
          chk("R2 address word", {16'b0, wrAddr}, {16'b0, a});
          chk("R2 data word", {16'b0, wrData}, {16'b0, d});
        end
      end else          chk("R4 strobe single", {31'b0, wrStrobe}, 32'd0);
      expD = 1'b0;
      expF = 1'b0;
      if (t >= 1 && t <= 16) begin
        expD = pend ? prevW[16 - t] : 1'b0;
        expF = pend && (t == 1);
      end else if (t >= 17 && t <= 32) begin
        expD = (hit && v) ? w[32 - t] : 1'b0;
        expF = hit && v && (t == 17);
      end
      chk("R6 R5 R3 R8 dataOut", {31'b0, dataOut}, {31'b0, expD});
      chk("R7 R8 frmOut", {31'b0, frmOut}, {31'b0, expF});
      if (t == 0 && prevStrb) begin rdValid = prevRd; rdWord = prevW; end
      if (t == 16)            begin rdValid = v;      rdWord = w;     end
      if (t < 16) begin
        frmIn  = frm[15 - t];
        addrIn = a[15 - t];
        dataIn = d[15 - t];
      end else begin
        frmIn = 1'b0; addrIn = 1'b0; dataIn = 1'b0;
      end
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nErr++;
      $display("FAIL watchdog: actual running expected done");
      $display("== %0d vectors applied, %0d miscompares ==", nChk, nErr);
      $finish;
    end
  end

  initial begin
    // R10: reset state
    repeat (3) @(negedge clk);
    chk("R10 strobe in reset", {31'b0, wrStrobe}, 32'd0);
    chk("R10 frmOut in reset", {31'b0, frmOut}, 32'd0);
    chk("R10 dataOut in reset", {31'b0, dataOut}, 32'd0);
    rstN = 1'b1;

    // R1: idle with frame lane low, other lanes busy
    addrIn = 1'b1; dataIn = 1'b1;
    for (int k = 0; k < 24; k++) begin
      @(negedge clk);
      chk("R1 idle no strobe", {31'b0, wrStrobe}, 32'd0);
      chk("R8 idle dataOut", {31'b0, dataOut}, 32'd0);
      chk("R8 idle frmOut", {31'b0, frmOut}, 32'd0);
    end
    addrIn = 1'b0; dataIn = 1'b0;

    // Sweep every chip ID against every frame chip number (R1..R9)
    for (int id = 0; id < 16; id++) begin
      chipId = 4'(id);
      for (int fc = 0; fc < 16; fc++) begin
        runCmd({1'b1, 4'(fc), 11'(id * 37 + fc * 5 + 1)},
               {4'(fc), 4'(id), 4'(id) ^ 4'h5, 4'(fc) ^ 4'hA},
               16'(id * 4099 + fc * 257 + 3),
               ((id + fc) % 3) != 0,
               16'h C3A5 ^ 16'(id << 4) ^ 16'(fc * 16'h1111),
               33, 1'b0, 1'b0, 16'h0);
      end
    end

    // R3: a foreign command overlapping a readback leaves it intact
    chipId = 4'd6;
    runCmd({1'b1, 4'd6, 11'h7FF}, 16'h1234, 16'hABCD, 1'b1, 16'hB00F, 15, 1'b0, 1'b0, 16'h0);
    runCmd({1'b1, 4'd9, 11'h7FF}, 16'hFFFF, 16'hFFFF, 1'b1, 16'h0000, 33, 1'b1, 1'b1, 16'hB00F);

    // R9: back-to-back accepted commands, both readable
    runCmd({1'b1, 4'd6, 11'h000}, 16'h8001, 16'h7FFE, 1'b1, 16'h8001, 15, 1'b0, 1'b0, 16'h0);
    runCmd({1'b1, 4'd6, 11'h555}, 16'h4242, 16'h0F0F, 1'b1, 16'hFFFF, 33, 1'b1, 1'b1, 16'h8001);

    // R5: readable then unreadable, back to back
    runCmd({1'b1, 4'd6, 11'h2AA}, 16'h0001, 16'h0002, 1'b1, 16'h5AA5, 15, 1'b0, 1'b0, 16'h0);
    runCmd({1'b1, 4'd6, 11'h123}, 16'h0003, 16'h0004, 1'b0, 16'hFFFF, 33, 1'b1, 1'b1, 16'h5AA5);

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nChk, nErr);
    $finish;
  end

endmodule